// File: doc/BRIEF.md
# Packet-Driven Bus Master Bridge

This block lets a remote host drive a memory-mapped bus. The host sends command packets as a stream of 32-bit words over a valid/ready input, three words per packet. The bridge decodes each packet and issues one single-beat transfer on a simplified AHB-Lite style master port. A write is posted: it goes into an eight-entry circular queue, is drained to the bus later and never produces a reply. A read waits until earlier writes have drained, performs the bus read and returns a three-word read-acknowledge packet on a valid/ready output.

Slave-side traffic can own the bus, and the block sees this as a busy input. A read that meets a busy bus does not hold the receiver while it waits. The read is recorded in a dedicated slot, which frees the packet buffer so that the receiver can collect the next packet. The bus read is attempted again once the bus goes idle. The host is stalled only because that next packet is not dispatched until the read has been acknowledged. The receiver never waits on the bus directly, so requests from either side cannot deadlock.

The master state machine has five states. IDLE is the resting state. REQ holds the address phase with NONSEQ. DATA is the data phase. DEFER holds a recorded read until the bus is free. RACK sends the acknowledge packet. Its transitions are:
- IDLE to REQ (start write) when the queue holds an entry, no read is waiting behind an empty queue, and the bus is not busy.
- IDLE to REQ (start read) when a read is recorded, the queue is empty and the bus is not busy.
- IDLE to DEFER when a read is recorded, the queue is empty and the bus is busy.
- DEFER to REQ when the busy input drops.
- REQ to DATA on hready.
- DATA to IDLE on hready for a write.
- DATA to RACK on hready for a read.
- RACK to IDLE when the last acknowledge word is taken.

Top module: `pkt_bus_bridge`

## Requirements
- R1: A packet is three input words: word 0 is the command type, word 1 the address and word 2 the data. After the third word is accepted, in_ready is low for at least the next cycle. No bus transfer starts for a packet until all three of its words are in.
- R2: Command type 1 is a write. It issues exactly one transfer with htrans=2'b10 (NONSEQ), hwrite=1 and the packet address, and drives the packet data on hwdata in the data phase. It produces no output packet.
- R3: Writes pass through an 8-entry first-in first-out queue. While the queue is full a complete write packet is held and in_ready stays low. No write is lost or reordered, including when a push and a pop fall in the same cycle.
- R4: Command type 0 is a read. It starts only after every earlier write has completed on the bus. It issues one NONSEQ transfer with hwrite=0 and returns three output words in this order: 2, the address, and the hrdata captured at the end of the data phase.
- R5: While hready is low during an address phase, htrans, haddr and hwrite hold their values. No phase completes without hready high.
- R6: While bus_busy is high no new transfer starts. A read that meets a busy bus releases the receiver, so in_ready is high again and one further packet can be collected. That packet is dispatched only after the read's acknowledge has been sent. The read is performed once bus_busy falls.
- R7: A command type other than 0 or 1 is dropped. It causes a one-cycle err_pulse, no bus transfer and no output packet.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_word does not change.
- R9: After reset, in_ready=1, out_valid=0, htrans=2'b00 and err_pulse=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command word valid |
| in_ready | output | 1 | Receiver can take a word |
| in_word | input | 32 | Command word |
| out_valid | output | 1 | Acknowledge word valid |
| out_ready | input | 1 | Acknowledge sink ready |
| out_word | output | 32 | Acknowledge word |
| haddr | output | 32 | Bus address |
| htrans | output | 2 | Transfer type: 00 idle, 10 NONSEQ |
| hwrite | output | 1 | Bus write when high |
| hwdata | output | 32 | Write data, valid in the data phase |
| hrdata | input | 32 | Read data |
| hready | input | 1 | Slave ready; low inserts wait states |
| bus_busy | input | 1 | Slave-side traffic holds the bus |
| err_pulse | output | 1 | One-cycle flag for a dropped packet |

## Verification
Two functions of this block can act in the same cycle.

The first pair is the receiver pushing a write into the queue while the master pops the oldest entry. Writes are streamed back to back while the slave inserts pseudo-random wait states, so pushes and pops coincide many times. Every address is then read back and compared with the value computed in the bench.

The second pair is a deferred read waiting on bus_busy while the receiver collects the next packet. That packet is a write to the same address. The acknowledge must carry the old value, and a later read must return the new one.

// File: rtl/pbb_pkg.sv
package pbb_pkg;
    localparam int unsigned CMD_RD  = 0;
    localparam int unsigned CMD_WR  = 1;
    localparam int unsigned CMD_ACK = 2;

    localparam logic [1:0] TR_IDLE   = 2'b00;
    localparam logic [1:0] TR_NONSEQ = 2'b10;

    typedef enum logic [2:0] {
        M_IDLE,
        M_REQ,
        M_DATA,
        M_DEFER,
        M_RACK
    } mstate_e;
endpackage

// File: rtl/pbb_rx.sv
module pbb_rx #(
    parameter int DW = 32,
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_word,
    input  logic          release_pkt,
    output logic          held,
    output logic [DW-1:0] pkt_type,
    output logic [AW-1:0] pkt_addr,
    output logic [DW-1:0] pkt_data
);
    logic [1:0] beat;

    assign in_ready = !held;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat     <= '0;
            held     <= 1'b0;
            pkt_type <= '0;
            pkt_addr <= '0;
            pkt_data <= '0;
        end else begin
            if (in_valid && in_ready) begin
                unique case (beat)
                    2'd0:    pkt_type <= in_word;
                    2'd1:    pkt_addr <= AW'(in_word);
                    default: pkt_data <= in_word;
                endcase
                if (beat == 2'd2) begin
                    beat <= '0;
                    held <= 1'b1;
                end else begin
                    beat <= beat + 2'd1;
                end
            end
            if (release_pkt) begin
                held <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pbb_wq.sv
module pbb_wq #(
    parameter int DW    = 32,
    parameter int AW    = 32,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [AW-1:0]                push_addr,
    input  logic [DW-1:0]                push_data,
    input  logic                         pop,
    output logic [AW-1:0]                head_addr,
    output logic [DW-1:0]                head_data,
    output logic                         full,
    output logic                         empty,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [AW-1:0] store_a [DEPTH];
    logic [DW-1:0] store_d [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;

    logic do_push, do_pop;
    assign full      = (count == CW'(DEPTH));
    assign empty     = (count == '0);
    assign do_push   = push && !full;
    assign do_pop    = pop && !empty;
    assign head_addr = store_a[rd_ptr];
    assign head_data = store_d[rd_ptr];

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            store_a[wr_ptr] <= push_addr;
            store_d[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wrap_inc(wr_ptr);
            if (do_pop)  rd_ptr <= wrap_inc(rd_ptr);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/pbb_master.sv
module pbb_master
    import pbb_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          q_empty,
    input  logic [AW-1:0] q_addr,
    input  logic [DW-1:0] q_data,
    output logic          q_pop,
    input  logic          rd_load,
    input  logic [AW-1:0] rd_addr_in,
    output logic          rd_busy,
    input  logic          bus_busy,
    output logic [AW-1:0] haddr,
    output logic [1:0]    htrans,
    output logic          hwrite,
    output logic [DW-1:0] hwdata,
    input  logic [DW-1:0] hrdata,
    input  logic          hready,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_word
);
    mstate_e       state, nxt;
    logic          rd_pend;
    logic [AW-1:0] rd_addr;
    logic [AW-1:0] cur_addr;
    logic [DW-1:0] cur_data;
    logic          cur_wr;
    logic [DW-1:0] rdata;
    logic [1:0]    beat;
    logic          start_wr, start_rd;

    assign rd_busy  = rd_pend;
    assign start_wr = (state == M_IDLE) && !q_empty && !bus_busy;
    assign start_rd = !bus_busy && (((state == M_IDLE) && rd_pend && q_empty)
                                    || (state == M_DEFER));
    assign q_pop    = start_wr;

    always_comb begin
        nxt = state;
        unique case (state)
            M_IDLE: begin
                if (start_wr || start_rd)         nxt = M_REQ;
                else if (rd_pend && q_empty)      nxt = M_DEFER;
            end
            M_DEFER: if (!bus_busy)               nxt = M_REQ;
            M_REQ:   if (hready)                  nxt = M_DATA;
            M_DATA:  if (hready)                  nxt = cur_wr ? M_IDLE : M_RACK;
            M_RACK:  if (out_ready && beat == 2'd2) nxt = M_IDLE;
            default:                              nxt = M_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= M_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend  <= 1'b0;
            rd_addr  <= '0;
            cur_addr <= '0;
            cur_data <= '0;
            cur_wr   <= 1'b0;
            rdata    <= '0;
            beat     <= '0;
        end else begin
            if (rd_load) begin
                rd_pend <= 1'b1;
                rd_addr <= rd_addr_in;
            end
            if (start_wr) begin
                cur_addr <= q_addr;
                cur_data <= q_data;
                cur_wr   <= 1'b1;
            end else if (start_rd) begin
                cur_addr <= rd_addr;
                cur_wr   <= 1'b0;
            end
            if (state == M_DATA && hready && !cur_wr) begin
                rdata <= hrdata;
                beat  <= '0;
            end
            if (state == M_RACK && out_ready) begin
                beat <= beat + 2'd1;
                if (beat == 2'd2) rd_pend <= 1'b0;
            end
        end
    end

    always_comb begin
        htrans    = TR_IDLE;
        haddr     = '0;
        hwrite    = 1'b0;
        hwdata    = '0;
        out_valid = 1'b0;
        out_word  = '0;
        unique case (state)
            M_REQ: begin
                htrans = TR_NONSEQ;
                haddr  = cur_addr;
                hwrite = cur_wr;
            end
            M_DATA: hwdata = cur_wr ? cur_data : '0;
            M_RACK: begin
                out_valid = 1'b1;
                unique case (beat)
                    2'd0:    out_word = DW'(CMD_ACK);
                    2'd1:    out_word = DW'(cur_addr);
                    default: out_word = rdata;
                endcase
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pkt_bus_bridge.sv
module pkt_bus_bridge
    import pbb_pkg::*;
#(
    parameter int DW    = 32,
    parameter int AW    = 32,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_word,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_word,
    output logic [AW-1:0] haddr,
    output logic [1:0]    htrans,
    output logic          hwrite,
    output logic [DW-1:0] hwdata,
    input  logic [DW-1:0] hrdata,
    input  logic          hready,
    input  logic          bus_busy,
    output logic          err_pulse
);
    localparam int CW = $clog2(DEPTH+1);

    logic          held, release_pkt;
    logic [DW-1:0] pkt_type, pkt_data;
    logic [AW-1:0] pkt_addr;
    logic          q_push, q_pop, q_full, q_empty;
    logic [AW-1:0] q_addr;
    logic [DW-1:0] q_data;
    logic [CW-1:0] wq_count;
    logic          rd_load, rd_busy, is_wr, is_rd, drop;

    pbb_rx #(.DW(DW), .AW(AW)) u_rx (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .release_pkt(release_pkt), .held(held),
        .pkt_type(pkt_type), .pkt_addr(pkt_addr), .pkt_data(pkt_data)
    );

    assign is_wr       = (pkt_type == DW'(CMD_WR));
    assign is_rd       = (pkt_type == DW'(CMD_RD));
    assign release_pkt = held && !rd_busy && !(is_wr && q_full);
    assign q_push      = release_pkt && is_wr;
    assign rd_load     = release_pkt && is_rd;
    assign drop        = release_pkt && !is_wr && !is_rd;

    always_ff @(posedge clk) begin
        if (!rst_n) err_pulse <= 1'b0;
        else        err_pulse <= drop;
    end

    pbb_wq #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) u_wq (
        .clk(clk), .rst_n(rst_n), .push(q_push), .push_addr(pkt_addr),
        .push_data(pkt_data), .pop(q_pop), .head_addr(q_addr),
        .head_data(q_data), .full(q_full), .empty(q_empty), .count(wq_count)
    );

    pbb_master #(.DW(DW), .AW(AW)) u_master (
        .clk(clk), .rst_n(rst_n), .q_empty(q_empty), .q_addr(q_addr),
        .q_data(q_data), .q_pop(q_pop), .rd_load(rd_load),
        .rd_addr_in(pkt_addr), .rd_busy(rd_busy), .bus_busy(bus_busy),
        .haddr(haddr), .htrans(htrans), .hwrite(hwrite), .hwdata(hwdata),
        .hrdata(hrdata), .hready(hready), .out_valid(out_valid),
        .out_ready(out_ready), .out_word(out_word)
    );
endmodule

// File: rtl/pkt_bus_bridge_chk.sv
module pkt_bus_bridge_chk #(
    parameter int DW    = 32,
    parameter int AW    = 32,
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_busy,
    input logic [1:0]    htrans,
    input logic [AW-1:0] haddr,
    input logic          hwrite,
    input logic          hready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [DW-1:0] out_word,
    input logic          err_pulse,
    input logic [CW-1:0] wq_count
);
    // R6: a new address phase only begins after a cycle with the bus free
    assert_start_when_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == 2'b10 && $past(htrans) != 2'b10) |-> !$past(bus_busy));

    // R5: address and control held through wait states
    assert_hold_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == 2'b10 && !hready) |=> (htrans == 2'b10 && $stable(haddr) && $stable(hwrite)));

    // R8: acknowledge word held under backpressure
    assert_ack_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

    // R4: the first acknowledge word carries type 2
    assert_ack_type_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(out_valid)) |-> (out_word == DW'(2)));

    // R7: error flag lasts one cycle
    assert_err_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> !err_pulse);

    // R3: the queue never holds more than its depth
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wq_count <= CW'(DEPTH));
endmodule

bind pkt_bus_bridge pkt_bus_bridge_chk #(.DW(DW), .AW(AW), .DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_busy(bus_busy), .htrans(htrans), .haddr(haddr),
    .hwrite(hwrite), .hready(hready), .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word), .err_pulse(err_pulse), .wq_count(wq_count)
);

// File: tb/pkt_bus_bridge_tb.sv
module pkt_bus_bridge_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_word;
    logic [31:0] haddr;
    logic [1:0]  htrans;
    logic        hwrite;
    logic [31:0] hwdata;
    logic [31:0] hrdata;
    logic        hready;
    logic        bus_busy = 1'b0;
    logic        err_pulse;

    always #2 clk = ~clk;

    pkt_bus_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
        .out_word(out_word), .haddr(haddr), .htrans(htrans), .hwrite(hwrite),
        .hwdata(hwdata), .hrdata(hrdata), .hready(hready), .bus_busy(bus_busy),
        .err_pulse(err_pulse)
    );

    // Slave model, wait-state generator and monitors
    logic [31:0] mem [16];
    logic [31:0] expv [16];
    logic        ws_mode = 1'b0;
    logic [7:0]  lfsr;
    logic        dp, dp_wr;
    logic [3:0]  dp_idx;
    int          n_xfers, err_cnt, ack_cnt;
    logic [31:0] ack_buf [256];

    assign hready = ws_mode ? lfsr[0] : 1'b1;
    assign hrdata = mem[dp_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr <= 8'h5B; dp <= 1'b0; dp_wr <= 1'b0; dp_idx <= '0;
            n_xfers <= 0; err_cnt <= 0; ack_cnt <= 0;
            for (int i = 0; i < 16; i++) mem[i] <= '0;
        end else begin
            lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            if (hready) begin
                if (dp && dp_wr) mem[dp_idx] <= hwdata;
                dp     <= (htrans == 2'b10);
                dp_wr  <= hwrite;
                dp_idx <= haddr[5:2];
                if (htrans == 2'b10) n_xfers <= n_xfers + 1;
            end
            if (err_pulse) err_cnt <= err_cnt + 1;
            if (out_valid && out_ready) begin
                ack_buf[ack_cnt[7:0]] <= out_word;
                ack_cnt <= ack_cnt + 1;
            end
        end
    end

    int checks = 0;
    int failures = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic send_word(input logic [31:0] w);
        while (!in_ready) begin
            in_valid = 1'b0;
            @(negedge clk);
        end
        in_valid = 1'b1;
        in_word  = w;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_pkt(input logic [31:0] t, input logic [31:0] a, input logic [31:0] d);
        send_word(t); send_word(a); send_word(d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_read(input logic [31:0] a, input logic [31:0] exp, input string req);
        int start;
        int guard;
        start = ack_cnt;
        send_pkt(32'd0, a, 32'h0);
        guard = 0;
        while (ack_cnt < start + 3 && guard < 400) begin
            @(negedge clk); guard++;
        end
        check(ack_cnt >= start + 3, req, 32'(ack_cnt - start), 32'd3);
        check(ack_buf[start[7:0]] == 32'd2, req, ack_buf[start[7:0]], 32'd2);
        check(ack_buf[8'(start + 1)] == a, req, ack_buf[8'(start + 1)], a);
        check(ack_buf[8'(start + 2)] == exp, req, ack_buf[8'(start + 2)], exp);
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 150000) begin
            failures++;
            $display("FAIL watchdog expired got=%h expected=%h", wd, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures + 0);
            $finish;
        end
    end

    initial begin
        int x0, a0, e0;
        idle(3);
        @(negedge clk);
        // R9 reset state
        check(in_ready == 1'b1, "R9 in_ready", 32'(in_ready), 1);
        check(out_valid == 1'b0, "R9 out_valid", 32'(out_valid), 0);
        check(htrans == 2'b00, "R9 htrans", 32'(htrans), 0);
        check(err_pulse == 1'b0, "R9 err_pulse", 32'(err_pulse), 0);
        rst_n = 1'b1;
        idle(2);

        // R2 sweep of writes, no acknowledge expected
        a0 = ack_cnt;
        for (int i = 0; i < 16; i++) begin
            expv[i] = (32'hA500_0000 ^ (32'(i) * 32'h0101_0101)) + 32'(i);
            send_pkt(32'd1, 32'(i * 4), expv[i]);
        end
        idle(40);
        check(ack_cnt == a0, "R2 no ack for writes", 32'(ack_cnt), 32'(a0));
        for (int i = 0; i < 16; i++) check(mem[i] == expv[i], "R2 write data", mem[i], expv[i]);
        for (int i = 0; i < 16; i += 5) do_read(32'(i * 4), expv[i], "R4 read ack");

        // R3 R5 overwrite under wait states: pushes and pops coincide
        ws_mode = 1'b1;
        for (int i = 0; i < 16; i++) begin
            expv[i] = 32'(i * i) + 32'd7;
            send_pkt(32'd1, 32'(i * 4), expv[i]);
        end
        for (int i = 0; i < 16; i++) do_read(32'(i * 4), expv[i], "R3 R5 read after waits");
        ws_mode = 1'b0;

        // R1 partial packet starts nothing; receiver busy after third word
        x0 = n_xfers;
        send_word(32'd1); send_word(32'd60);
        idle(5);
        check(n_xfers == x0, "R1 partial packet", 32'(n_xfers), 32'(x0));
        send_word(32'h0000_5A5A);
        check(in_ready == 1'b0, "R1 ready low after packet", 32'(in_ready), 0);
        expv[15] = 32'h0000_5A5A;
        idle(10);
        check(mem[15] == expv[15], "R1 write completes", mem[15], expv[15]);

        // R3 queue full holds the ninth write
        bus_busy = 1'b1;
        x0 = n_xfers;
        for (int i = 0; i < 9; i++) begin
            expv[i] = 32'd1000 + 32'(i);
            send_pkt(32'd1, 32'(i * 4), expv[i]);
        end
        idle(4);
        check(in_ready == 1'b0, "R3 full stalls receiver", 32'(in_ready), 0);
        check(n_xfers == x0, "R6 busy blocks writes", 32'(n_xfers), 32'(x0));
        bus_busy = 1'b0;
        idle(40);
        for (int i = 0; i < 9; i++) check(mem[i] == expv[i], "R3 no write lost", mem[i], expv[i]);

        // R6 deferred read releases the receiver; later write must not overtake
        bus_busy = 1'b1;
        x0 = n_xfers; a0 = ack_cnt;
        send_pkt(32'd0, 32'd4, 32'd0);
        idle(5);
        check(in_ready == 1'b1, "R6 receiver released", 32'(in_ready), 1);
        check(n_xfers == x0, "R6 read deferred", 32'(n_xfers), 32'(x0));
        check(ack_cnt == a0, "R6 no ack while busy", 32'(ack_cnt), 32'(a0));
        send_pkt(32'd1, 32'd4, 32'hDEAD_0004);
        idle(2);
        check(in_ready == 1'b0, "R6 next packet held", 32'(in_ready), 0);
        bus_busy = 1'b0;
        idle(20);
        check(ack_cnt == a0 + 3, "R6 ack count", 32'(ack_cnt), 32'(a0 + 3));
        check(ack_buf[8'(a0 + 2)] == expv[1], "R6 read sees old value", ack_buf[8'(a0 + 2)], expv[1]);
        expv[1] = 32'hDEAD_0004;
        do_read(32'd4, expv[1], "R6 later write applied");

        // R7 illegal types are dropped
        x0 = n_xfers; a0 = ack_cnt; e0 = err_cnt;
        send_pkt(32'd5, 32'd0, 32'h0000_0BAD);
        send_pkt(32'd2, 32'd0, 32'h0000_0BAD);
        idle(6);
        check(err_cnt == e0 + 2, "R7 error pulses", 32'(err_cnt), 32'(e0 + 2));
        check(n_xfers == x0, "R7 no bus transfer", 32'(n_xfers), 32'(x0));
        check(ack_cnt == a0, "R7 no ack", 32'(ack_cnt), 32'(a0));
        do_read(32'd0, expv[0], "R7 memory untouched");

        // R8 backpressure on acknowledge
        out_ready = 1'b0;
        a0 = ack_cnt;
        send_pkt(32'd0, 32'd8, 32'd0);
        idle(10);
        check(out_valid == 1'b1, "R8 valid held", 32'(out_valid), 1);
        check(out_word == 32'd2, "R8 first word held", out_word, 32'd2);
        out_ready = 1'b1;
        idle(6);
        check(ack_cnt == a0 + 3, "R8 ack delivered", 32'(ack_cnt), 32'(a0 + 3));
        check(ack_buf[8'(a0 + 2)] == expv[2], "R8 ack data", ack_buf[8'(a0 + 2)], expv[2]);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule